// File: doc/BRIEF.md
# Level-Shifted Sinusoidal PWM Gate Generator

This block turns a signed modulation command into the ten gate bits of a single-phase, seven-level switching stage. The command's magnitude picks one of three stacked amplitude bands. Each band has its own triangular carrier, shifted up by a third of full scale. The command is compared with all three carriers. The result of each comparison drives exactly one switch of the active half-bridge pattern. Because the bands are stacked, only the switch that belongs to the band holding the command toggles at carrier rate. The switches below that band stay on, and the switches above it stay off.

The command's sign selects the half-cycle. The four line-rate switches (the two rails and the two returns) follow that sign. The sign is captured only at carrier-period boundaries, so the line-rate switches never change inside a carrier period. Out of reset the block keeps every gate off for the whole of the first carrier period. The gate outputs are registered, one clock behind the command and the carrier. Dead time and driver interfacing belong to the stage that follows.

Top module: `lspwm_gate_gen`

## Requirements
- R1: The carrier is a triangle that rises from 0 to PEAK = (2^MAG_W-1)/3 (341 by default) and falls back, so one period is 2*PEAK clocks. Cycle k of a period has carrier value k for k <= PEAK and 2*PEAK-k otherwise. Band b (b = 0, 1, 2) is on while the command magnitude is strictly greater than b*PEAK plus the carrier.
- R2: In the positive half-cycle, gate bits 0 and 7 are on and gate bits 1, 4, 5, 6 and 8 are off. Gate bit n drives switch position n+1.
- R3: For a magnitude of at most PEAK in the positive half-cycle, bit 3 follows band 0, and bits 2 and 9 are off.
- R4: For a magnitude between PEAK+1 and 2*PEAK in the positive half-cycle, bit 3 is on, bit 2 follows band 1, and bit 9 is off.
- R5: For a magnitude above 2*PEAK in the positive half-cycle, bits 3 and 2 are on and bit 9 follows band 2.
- R6: In the negative half-cycle, bits 1 and 6 are on. Bits 5, 4 and 8 take the roles that bits 3, 2 and 9 have in the positive half-cycle. Bits 0, 2, 3, 7 and 9 are off.
- R7: The half-cycle is negative when the command's sign bit is 1. Zero counts as positive. The half-cycle is sampled in the last clock of each carrier period and takes effect from the next period.
- R8: The command is an (MAG_W+1)-bit two's-complement value. Its magnitude is saturated to 2^MAG_W-1, so the most negative code acts as full scale.
- R9: All gates are off while reset is asserted and for the first 2*PEAK clocks after its release.
- R10: The gate outputs in a clock reflect the command, carrier and half-cycle of the previous clock.
- R11: While the command is held for two clocks and no carrier-period boundary lies between them, at most one gate bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cmd_i | input | MAG_W+1 | Signed modulation command |
| gate_o | output | 10 | Gate bits; bit n drives switch position n+1 |

## Verification
The assertions assume that reset is released in step with the clock. They also assume that a command may take any code, including the most negative one. The single-toggle property applies only when the command stays the same over the two clocks that produced a gate pair, so it does not fire when the command jumps by a large step.

The stimulus holds directed commands at the band edges (PEAK, PEAK+1, 2*PEAK, 2*PEAK+1, full scale, the most negative code) for more than a full period. In random mode it keeps each command for several clocks on average, so the conditional properties are exercised often. Sign changes land at arbitrary points inside a carrier period, and one reset is applied mid-run, to stress the boundary capture and the quiet period.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

  localparam int NUM_BANDS = 3;
  localparam int NUM_SW    = 10;

  // Bit positions of the switches in the gate vector.
  localparam int SW_POS_RAIL = 0;
  localparam int SW_NEG_RAIL = 1;
  localparam int SW_POS_MID  = 2;
  localparam int SW_POS_LOW  = 3;
  localparam int SW_NEG_MID  = 4;
  localparam int SW_NEG_LOW  = 5;
  localparam int SW_NEG_RET  = 6;
  localparam int SW_POS_RET  = 7;
  localparam int SW_NEG_TOP  = 8;
  localparam int SW_POS_TOP  = 9;

  typedef enum logic {
    HALF_POS = 1'b0,
    HALF_NEG = 1'b1
  } half_e;

  typedef logic [NUM_SW-1:0] gate_vec_t;

  // Switch driven by band b in a given half-cycle.
  function automatic int band_switch(input half_e half, input int b);
    int sw;
    if (half == HALF_POS) begin
      case (b)
        0:       sw = SW_POS_LOW;
        1:       sw = SW_POS_MID;
        default: sw = SW_POS_TOP;
      endcase
    end else begin
      case (b)
        0:       sw = SW_NEG_LOW;
        1:       sw = SW_NEG_MID;
        default: sw = SW_NEG_TOP;
      endcase
    end
    return sw;
  endfunction

endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
  parameter int PEAK  = 341,
  parameter int CAR_W = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CAR_W-1:0] car_o,
  output logic             last_o
);

  localparam logic [CAR_W-1:0] TOP     = CAR_W'(PEAK);
  localparam logic [CAR_W-1:0] BELOW_T = CAR_W'(PEAK - 1);
  localparam logic [CAR_W-1:0] ONE     = CAR_W'(1);

  logic [CAR_W-1:0] car_q, car_d;
  logic             down_q, down_d;
  logic             step_en;

  assign step_en = 1'b1;

  always_comb begin
    car_d  = car_q;
    down_d = down_q;
    if (!down_q) begin
      car_d = car_q + ONE;
      if (car_q == BELOW_T) begin
        car_d  = TOP;
        down_d = 1'b1;
      end
    end else begin
      car_d = car_q - ONE;
      if (car_q == ONE) begin
        down_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q  <= '0;
      down_q <= 1'b0;
    end else if (step_en) begin
      car_q  <= car_d;
      down_q <= down_d;
    end
  end

  assign car_o  = car_q;
  assign last_o = down_q && (car_q == ONE);

endmodule

// File: rtl/lspwm_band_cmp.sv
module lspwm_band_cmp
  import lspwm_pkg::*;
#(
  parameter int MAG_W = 10,
  parameter int PEAK  = 341,
  parameter int CAR_W = 9
) (
  input  logic [MAG_W-1:0]     mag_i,
  input  logic [CAR_W-1:0]     car_i,
  output logic [NUM_BANDS-1:0] above_o
);

  localparam int CW = MAG_W + 1;

  logic [CW-1:0] mag_x;
  logic [CW-1:0] car_x;

  assign mag_x = CW'(mag_i);
  assign car_x = CW'(car_i);

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam logic [CW-1:0] OFFS = CW'(b * PEAK);
    logic [CW-1:0] level;
    assign level      = OFFS + car_x;
    assign above_o[b] = mag_x > level;
  end

endmodule

// File: rtl/lspwm_switch_map.sv
module lspwm_switch_map
  import lspwm_pkg::*;
(
  input  logic                 en_i,
  input  half_e                half_i,
  input  logic [NUM_BANDS-1:0] above_i,
  output gate_vec_t            gate_o
);

  always_comb begin
    gate_o = '0;
    if (en_i) begin
      if (half_i == HALF_POS) begin
        gate_o[SW_POS_RAIL] = 1'b1;
        gate_o[SW_POS_RET]  = 1'b1;
      end else begin
        gate_o[SW_NEG_RAIL] = 1'b1;
        gate_o[SW_NEG_RET]  = 1'b1;
      end
      for (int b = 0; b < NUM_BANDS; b++) begin
        gate_o[band_switch(half_i, b)] = above_i[b];
      end
    end
  end

endmodule

// File: rtl/lspwm_gate_gen.sv
module lspwm_gate_gen
  import lspwm_pkg::*;
#(
  parameter int MAG_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [MAG_W:0]   cmd_i,
  output logic [NUM_SW-1:0]       gate_o
);

  localparam int PEAK  = ((1 << MAG_W) - 1) / NUM_BANDS;
  localparam int CAR_W = $clog2(PEAK + 1);

  logic [CAR_W-1:0]     car;
  logic                 period_last;
  logic [MAG_W-1:0]     low_bits;
  logic [MAG_W-1:0]     neg_mag;
  logic [MAG_W-1:0]     mag;
  logic                 cmd_neg;
  logic [NUM_BANDS-1:0] band_above;
  gate_vec_t            mapped;

  logic  armed_q, armed_d, armed_en;
  half_e half_q, half_d;
  logic  half_en;
  gate_vec_t gate_q, gate_d;
  logic  gate_en;

  lspwm_carrier #(.PEAK(PEAK), .CAR_W(CAR_W)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .car_o  (car),
    .last_o (period_last)
  );

  // Magnitude with saturation of the most negative code.
  assign cmd_neg  = cmd_i[MAG_W];
  assign low_bits = cmd_i[MAG_W-1:0];
  assign neg_mag  = ~low_bits + MAG_W'(1);

  always_comb begin
    if (!cmd_neg) begin
      mag = low_bits;
    end else if (low_bits == '0) begin
      mag = '1;
    end else begin
      mag = neg_mag;
    end
  end

  lspwm_band_cmp #(.MAG_W(MAG_W), .PEAK(PEAK), .CAR_W(CAR_W)) u_cmp (
    .mag_i   (mag),
    .car_i   (car),
    .above_o (band_above)
  );

  lspwm_switch_map u_map (
    .en_i    (armed_q),
    .half_i  (half_q),
    .above_i (band_above),
    .gate_o  (mapped)
  );

  // Next state
  always_comb begin
    armed_en = period_last;
    armed_d  = 1'b1;
    half_en  = period_last;
    half_d   = cmd_neg ? HALF_NEG : HALF_POS;
    gate_en  = 1'b1;
    gate_d   = mapped;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      half_q  <= HALF_POS;
      gate_q  <= '0;
    end else begin
      if (armed_en) armed_q <= armed_d;
      if (half_en)  half_q  <= half_d;
      if (gate_en)  gate_q  <= gate_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/lspwm_gate_gen_chk.sv
module lspwm_gate_gen_chk
  import lspwm_pkg::*;
#(
  parameter int MAG_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic signed [MAG_W:0] cmd_i,
  input logic [NUM_SW-1:0]     gate_o,
  input logic                  armed,
  input logic                  period_last,
  input logic [NUM_BANDS-1:0]  band_above
);

  localparam gate_vec_t ONE_B = gate_vec_t'(1);
  localparam gate_vec_t POS_SET = (ONE_B << SW_POS_RAIL) | (ONE_B << SW_POS_RET) |
                                  (ONE_B << SW_POS_LOW)  | (ONE_B << SW_POS_MID) |
                                  (ONE_B << SW_POS_TOP);
  localparam gate_vec_t NEG_SET = (ONE_B << SW_NEG_RAIL) | (ONE_B << SW_NEG_RET) |
                                  (ONE_B << SW_NEG_LOW)  | (ONE_B << SW_NEG_MID) |
                                  (ONE_B << SW_NEG_TOP);
  localparam gate_vec_t FIX_SET = (ONE_B << SW_POS_RAIL) | (ONE_B << SW_POS_RET) |
                                  (ONE_B << SW_NEG_RAIL) | (ONE_B << SW_NEG_RET);

  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 2'd1;
    end
  end

  // R1: a higher band can only be on when every lower band is on.
  assert_band_stack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (band_above[2] |-> band_above[1]) and (band_above[1] |-> band_above[0]));

  // R6: the two half-cycle switch sets are never active together.
  assert_half_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(gate_o & POS_SET)) && (|(gate_o & NEG_SET))));

  // R9: no gate is on before the block has armed.
  assert_quiet_until_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd0 && !$past(armed)) |-> (gate_o == '0));

  // R7: line-rate switches change only just after a period boundary.
  assert_fixed_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && ((gate_o & FIX_SET) != ($past(gate_o) & FIX_SET)))
      |-> $past(period_last, 2));

  // R11: one device at a time under a steady command.
  assert_single_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3 && $past(cmd_i) == $past(cmd_i, 2) && !$past(period_last, 2))
      |-> ($countones(gate_o ^ $past(gate_o)) <= 1));

endmodule

bind lspwm_gate_gen lspwm_gate_gen_chk #(.MAG_W(MAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .gate_o      (gate_o),
  .armed       (armed_q),
  .period_last (period_last),
  .band_above  (band_above)
);

// File: tb/lspwm_gate_gen_tb_top.sv
module lspwm_gate_gen_tb_top;

  localparam int MAG_W  = 10;
  localparam int PEAK   = ((1 << MAG_W) - 1) / 3;
  localparam int P      = 2 * PEAK;
  localparam int MAXMAG = (1 << MAG_W) - 1;
  localparam logic [9:0] FIX_MASK = 10'b0011000011;
  localparam logic [9:0] MOD_MASK = ~FIX_MASK;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic signed [MAG_W:0] cmd = '0;
  logic [9:0]            gate;

  always #4 clk = ~clk;

  lspwm_gate_gen #(.MAG_W(MAG_W)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd),
    .gate_o (gate)
  );

  int checks = 0;
  int errors = 0;
  int k;
  logic pol_m;
  logic signed [MAG_W:0] cur_cmd, prev_cmd;
  logic [9:0] exp_g, prev_gate;
  logic prev_valid;
  string tag_fix, tag_mod;
  int duty_cnt;
  logic duty_en = 1'b0;

  function automatic int mag_of(input logic signed [MAG_W:0] c);
    int m;
    m = (c < 0) ? -int'(c) : int'(c);
    if (m > MAXMAG) m = MAXMAG;  // R8 saturation
    return m;
  endfunction

  // Expected gates produced from cycle kk (R1 carrier, R2..R6 mapping, R9 quiet).
  function automatic logic [9:0] expect_gates(input int kk, input logic signed [MAG_W:0] c,
                                              input logic p);
    logic [9:0] g;
    int t, tr, m;
    g = '0;
    if (kk < P) return g;
    t  = kk % P;
    tr = (t <= PEAK) ? t : P - t;
    m  = mag_of(c);
    if (!p) begin
      g[0] = 1'b1; g[7] = 1'b1;
      g[3] = m > tr; g[2] = m > PEAK + tr; g[9] = m > 2 * PEAK + tr;
    end else begin
      g[1] = 1'b1; g[6] = 1'b1;
      g[5] = m > tr; g[4] = m > PEAK + tr; g[8] = m > 2 * PEAK + tr;
    end
    return g;
  endfunction

  task automatic set_expect();
    int m;
    exp_g = expect_gates(k, cur_cmd, pol_m);
    m = mag_of(cur_cmd);
    if (k < P) begin
      tag_fix = "R9"; tag_mod = "R9";
    end else begin
      if (pol_m != cur_cmd[MAG_W]) tag_fix = "R7";
      else tag_fix = pol_m ? "R6" : "R2";
      if (cur_cmd == -(1 <<< MAG_W)) tag_mod = "R8 (R10 latency)";
      else if (pol_m) tag_mod = "R6 (R10 latency)";
      else if (m <= PEAK) tag_mod = "R3 (R10 latency)";
      else if (m <= 2 * PEAK) tag_mod = "R4 (R10 latency)";
      else tag_mod = "R5 (R10 latency)";
    end
  endtask

  task automatic check_vec(input string tag, input logic [9:0] act, input logic [9:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: gate=%b expected=%b (cycle %0d)", tag, act, expv, k);
    end
  endtask

  // One clock: check the output produced by cycle k, then apply the next command.
  task automatic step(input logic signed [MAG_W:0] c);
    @(negedge clk);
    check_vec(tag_fix, gate & FIX_MASK, exp_g & FIX_MASK);
    check_vec(tag_mod, gate & MOD_MASK, exp_g & MOD_MASK);
    // R11: steady command, no boundary between the two producing cycles.
    if (prev_valid && k >= 1 && (k % P) != 0 && cur_cmd == prev_cmd) begin
      checks++;
      if ($countones(gate ^ prev_gate) > 1) begin
        errors++;
        $display("FAIL R11: changed bits=%0d expected<=1", $countones(gate ^ prev_gate));
      end
    end
    if (duty_en && gate[3]) duty_cnt++;
    prev_gate  = gate;
    prev_cmd   = cur_cmd;
    prev_valid = 1'b1;
    if ((k % P) == P - 1) pol_m = cur_cmd[MAG_W];  // R7 capture
    k++;
    cmd     = c;
    cur_cmd = c;
    set_expect();
  endtask

  task automatic do_reset(input logic signed [MAG_W:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_vec("R9", gate, 10'b0);  // asynchronous clear
    repeat (3) @(negedge clk);
    check_vec("R9", gate, 10'b0);
    cmd     = c;
    cur_cmd = c;
    rst_n   = 1'b1;
    k       = 0;
    pol_m   = 1'b0;
    prev_valid = 1'b0;
    set_expect();
  endtask

  initial begin
    int dir_vals[13];
    logic signed [MAG_W:0] rv;
    void'($urandom(32'd715));
    dir_vals = '{0, PEAK, PEAK + 1, 500, 2 * PEAK, 2 * PEAK + 1, MAXMAG,
                 -1, -PEAK, -600, -(1 << MAG_W), -MAXMAG, 900};
    #1;
    check_vec("R9", gate, 10'b0);
    do_reset(11'sd171);
    // Quiet period, then a duty measurement in band 0 (R1).
    repeat (P + 3) step(11'sd171);
    duty_cnt = 0;
    duty_en  = 1'b1;
    repeat (P) step(11'sd171);
    duty_en  = 1'b0;
    checks++;
    if (duty_cnt != PEAK) begin  // R1: tri < 171 in 341 of 682 clocks
      errors++;
      $display("FAIL R1: on-count=%0d expected=%0d", duty_cnt, PEAK);
    end
    // Directed band edges and saturation (R3 R4 R5 R6 R8).
    foreach (dir_vals[i]) begin
      repeat (P + 3) step(11'(dir_vals[i]));
    end
    // Sign flips inside a period (R7).
    repeat (P / 3) step(11'sd300);
    repeat (P / 2) step(-11'sd300);
    repeat (P) step(-11'sd300);
    // Random, held for several clocks on average.
    rv = '0;
    for (int n = 0; n < 30000; n++) begin
      if (($urandom % 16) == 0) rv = 11'($urandom_range(2047)) ;
      step(rv);
    end
    do_reset(-11'sd800);
    repeat (P + 2) step(-11'sd800);
    for (int n = 0; n < 30000; n++) begin
      if (($urandom % 8) == 0) rv = 11'($urandom_range(2047));
      step(rv);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=190000 expected completion earlier");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule